// File: doc/BRIEF.md
# Credit-Gated Byte Link Framer

This block is the byte-level engine for one end of a full-duplex, point-to-point serial link in which every byte slot carries one byte out and one byte in. The shift register that moves the bits sits outside the block. It pulses `slot` once per byte time, presents the byte it just received on `rx_byte`, and takes whatever is on `tx_byte` as the byte to send in that slot. Each direction of the link is either in control mode or in data mode. A control byte advertises the receive space that is free at the sending end and announces how much data follows it.

The transmit side accepts a request that gives a byte count. It waits until the peer has advertised enough credit, sends a control byte that announces the burst in 8-byte words, and then streams the payload from a local source. The last word is padded with zero bytes. The receive side parses the incoming control bytes, keeps the peer's most recent credit, and passes incoming data bytes to a local sink one at a time. The two directions run independently of each other.

Top module: `flc_link_framer`

## Requirements
- R1: After reset, both directions are in control mode, `busy`, `err` and `sink_valid` are low, and the stored peer credit is zero, so an accepted request sends no data until the peer advertises credit.
- R2: In control mode, `tx_byte` has bits [7:6] at 0, bits [5:3] holding the number of 8-byte words that follow (0 when no burst starts in this slot), and bits [2:0] holding the local credit.
- R3: The local credit is floor(`sink_free`/8), capped at 7.
- R4: Every byte received in control mode loads bits [2:0] into the stored peer credit in the slot edge where it arrives. Bits [7:6] are ignored.
- R5: A control byte received with a nonzero count N in bits [5:3] makes the next 8*N received bytes data. Each one is presented on `sink_data` with a one-cycle `sink_valid` in the cycle after its slot. The receive direction then returns to control mode.
- R6: Bytes received in data mode never change the stored peer credit.
- R7: A request with a length L from 1 to 56 is accepted when the transmit side is idle, and `busy` rises in the next cycle. The burst starts in the first control-mode slot where the stored peer credit is at least ceil(L/8). That slot sends the announcing control byte, and the following 8*ceil(L/8) slots carry data.
- R8: The data slots carry the source bytes in order for the first L slots. `src_take` is high in exactly those slots, and the remaining slots of the burst carry 0x00.
- R9: `busy` falls in the cycle after the last data slot of a burst, and the transmit direction is then in control mode.
- R10: A request made while idle with a length of 0 or above 56 raises `err` for exactly one cycle and is not accepted: `busy` stays low and no data is announced.
- R11: A request made while `busy` is high is ignored, and the current burst goes on unchanged.
- R12: Receive parsing continues while the transmit side is in data mode, and the reverse also holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot | input | 1 | One-cycle strobe marking a byte slot |
| rx_byte | input | 8 | Byte received in this slot |
| tx_byte | output | 8 | Byte to send in this slot |
| sink_free | input | 8 | Free bytes in the local receive buffer |
| sink_valid | output | 1 | A received data byte is on `sink_data` |
| sink_data | output | 8 | Received data byte |
| req | input | 1 | Send request strobe |
| req_len | input | 6 | Payload length of the request, in bytes |
| src_data | input | 8 | Current payload byte from the local source |
| src_take | output | 1 | The source byte is consumed in this slot |
| busy | output | 1 | A send request is pending or in progress |
| err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The bench aims at the slot boundaries around credit. If a design read the credit from the same slot instead of from earlier slots, it would announce a burst one slot too early. If it loaded credit from data bytes, it would start a burst that a stale 0x3F payload byte had permitted. Lengths of 1, 9 and 56 exercise the padding. A design that counted payload bytes wrongly would send source bytes where zeros belong, or would release `busy` a slot early. Requests of 0, 57 and 63 bytes, and requests made while busy, catch a design that accepts bad lengths or lets a second request corrupt a burst in flight.

// File: rtl/flc_pkg.sv
package flc_pkg;
    localparam int CNT_W      = 3;
    localparam int WORD_SHIFT = 3;
    localparam int LEN_W      = CNT_W + WORD_SHIFT;
    localparam int MAX_WORDS  = (1 << CNT_W) - 1;
    localparam int MAX_BYTES  = MAX_WORDS << WORD_SHIFT;

    typedef enum logic {
        MODE_CTRL = 1'b0,
        MODE_DATA = 1'b1
    } dir_mode_e;

    typedef struct packed {
        dir_mode_e        mode;
        logic             busy;
        logic             err;
        logic [CNT_W-1:0] words;
        logic [LEN_W-1:0] left;
        logic [LEN_W-1:0] rem;
    } tx_state_t;

    typedef struct packed {
        dir_mode_e        mode;
        logic [LEN_W-1:0] rem;
        logic [CNT_W-1:0] pcred;
        logic             sval;
        logic [7:0]       sdat;
    } rx_state_t;
endpackage

// File: rtl/flc_credit.sv
module flc_credit
    import flc_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic [FREE_W-1:0] sink_free,
    output logic [CNT_W-1:0]  local_credit
);
    logic [FREE_W-1:0] words_avail;

    always_comb begin
        words_avail = sink_free >> WORD_SHIFT;
        if (words_avail > FREE_W'(MAX_WORDS))
            local_credit = CNT_W'(MAX_WORDS);
        else
            local_credit = words_avail[CNT_W-1:0];
    end
endmodule

// File: rtl/flc_rx.sv
module flc_rx
    import flc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot,
    input  logic [7:0]       rx_byte,
    output logic [CNT_W-1:0] peer_credit,
    output logic             sink_valid,
    output logic [7:0]       sink_data
);
    rx_state_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.sval = 1'b0;
        if (slot) begin
            if (rx_q.mode == MODE_CTRL) begin
                rx_d.pcred = rx_byte[CNT_W-1:0];
                if (rx_byte[2*CNT_W-1:CNT_W] != '0) begin
                    rx_d.mode = MODE_DATA;
                    rx_d.rem  = {rx_byte[2*CNT_W-1:CNT_W], {WORD_SHIFT{1'b0}}};
                end
            end else begin
                rx_d.sval = 1'b1;
                rx_d.sdat = rx_byte;
                rx_d.rem  = rx_q.rem - LEN_W'(1);
                if (rx_q.rem == LEN_W'(1))
                    rx_d.mode = MODE_CTRL;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign peer_credit = rx_q.pcred;
    assign sink_valid  = rx_q.sval;
    assign sink_data   = rx_q.sdat;

    // R5
    sink_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sink_valid |-> $past(slot));

    // R6
    credit_frozen_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.mode == MODE_DATA) |=> $stable(peer_credit));

    // R5
    data_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q.mode == MODE_DATA) |-> (rx_q.rem != '0));
endmodule

// File: rtl/flc_tx.sv
module flc_tx
    import flc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot,
    input  logic             req,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       src_data,
    input  logic [CNT_W-1:0] peer_credit,
    input  logic [CNT_W-1:0] local_credit,
    output logic [7:0]       tx_byte,
    output logic             src_take,
    output logic             busy,
    output logic             err
);
    tx_state_t        tx_d, tx_q;
    logic [CNT_W-1:0] words_req;
    logic             len_ok;
    logic             launch;

    always_comb begin
        words_req = req_len[LEN_W-1:WORD_SHIFT]
                  + CNT_W'(|req_len[WORD_SHIFT-1:0]);
        len_ok    = (req_len != '0) && (req_len <= LEN_W'(MAX_BYTES));
        launch    = (tx_q.mode == MODE_CTRL) && tx_q.busy
                  && (peer_credit >= tx_q.words);

        if (tx_q.mode == MODE_CTRL)
            tx_byte = {2'b00, (launch ? tx_q.words : {CNT_W{1'b0}}), local_credit};
        else
            tx_byte = (tx_q.left != '0) ? src_data : 8'h00;
        src_take = slot && (tx_q.mode == MODE_DATA) && (tx_q.left != '0);

        tx_d     = tx_q;
        tx_d.err = 1'b0;
        if (req && !tx_q.busy) begin
            if (len_ok) begin
                tx_d.busy  = 1'b1;
                tx_d.words = words_req;
                tx_d.left  = req_len;
            end else begin
                tx_d.err = 1'b1;
            end
        end
        if (slot) begin
            if (launch) begin
                tx_d.mode = MODE_DATA;
                tx_d.rem  = {tx_q.words, {WORD_SHIFT{1'b0}}};
            end else if (tx_q.mode == MODE_DATA) begin
                tx_d.rem = tx_q.rem - LEN_W'(1);
                if (tx_q.left != '0)
                    tx_d.left = tx_q.left - LEN_W'(1);
                if (tx_q.rem == LEN_W'(1)) begin
                    tx_d.mode = MODE_CTRL;
                    tx_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign busy = tx_q.busy;
    assign err  = tx_q.err;

    // R7
    announce_within_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && tx_q.mode == MODE_CTRL && tx_byte[5:3] != '0)
            |-> (tx_byte[5:3] <= peer_credit));

    // R2
    ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q.mode == MODE_CTRL) |-> (tx_byte[7:6] == 2'b00));

    // R9
    idle_in_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (tx_q.mode == MODE_CTRL));

    // R10
    reject_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !busy);

    // R8
    take_only_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_take |-> (busy && slot));
endmodule

// File: rtl/flc_link_framer.sv
module flc_link_framer
    import flc_pkg::*;
#(
    parameter int FREE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot,
    input  logic [7:0]        rx_byte,
    output logic [7:0]        tx_byte,
    input  logic [FREE_W-1:0] sink_free,
    output logic              sink_valid,
    output logic [7:0]        sink_data,
    input  logic              req,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [7:0]        src_data,
    output logic              src_take,
    output logic              busy,
    output logic              err
);
    logic [CNT_W-1:0] local_credit;
    logic [CNT_W-1:0] peer_credit;

    flc_credit #(.FREE_W(FREE_W)) u_credit (
        .sink_free    (sink_free),
        .local_credit (local_credit)
    );

    flc_rx u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot        (slot),
        .rx_byte     (rx_byte),
        .peer_credit (peer_credit),
        .sink_valid  (sink_valid),
        .sink_data   (sink_data)
    );

    flc_tx u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot         (slot),
        .req          (req),
        .req_len      (req_len),
        .src_data     (src_data),
        .peer_credit  (peer_credit),
        .local_credit (local_credit),
        .tx_byte      (tx_byte),
        .src_take     (src_take),
        .busy         (busy),
        .err          (err)
    );

    // R3
    credit_fits_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({{(FREE_W-LEN_W){1'b0}}, local_credit, {WORD_SHIFT{1'b0}}} <= sink_free));

    // R3
    credit_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sink_free >= FREE_W'(MAX_BYTES)) |-> (local_credit == CNT_W'(MAX_WORDS)));
endmodule

// File: tb/flc_link_framer_bench.sv
module flc_link_framer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot = 1'b0;
    logic       req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] src_data = 8'h00;
    logic [7:0] sink_free = 8'h00;
    logic [5:0] req_len = 6'd0;
    logic [7:0] tx_byte, sink_data;
    logic       sink_valid, src_take, busy, err;

    flc_link_framer u_flc_link_framer (
        .clk(clk), .rst_n(rst_n), .slot(slot), .rx_byte(rx_byte), .tx_byte(tx_byte),
        .sink_free(sink_free), .sink_valid(sink_valid), .sink_data(sink_data),
        .req(req), .req_len(req_len), .src_data(src_data), .src_take(src_take),
        .busy(busy), .err(err)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    bit         m_busy = 0;
    bit         m_data = 0;
    int         m_words = 0, m_len = 0, m_sent = 0, m_rem = 0, m_pc = 0;
    int         pr_rem = 0;
    logic [7:0] payload [64];
    logic [7:0] last_tx;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] lc_of(input logic [7:0] f);
        return ((f >> 3) > 7) ? 3'd7 : f[5:3];
    endfunction

    task automatic fill(input int len);
        for (int i = 0; i < 64; i++) payload[i] = 8'($urandom);
    endtask

    task automatic do_slot(input logic [7:0] rb);
        logic [7:0] e;
        int ann;
        bit got;
        @(negedge clk);
        rx_byte = rb;
        slot = 1'b1;
        src_data = payload[m_sent];
        #1;
        if (!m_data) begin
            ann = (m_busy && m_pc >= m_words) ? m_words : 0;
            e = {2'b00, 3'(ann), lc_of(sink_free)};
            chk("R2 R3 R4 R7 control byte", tx_byte, e);
            chk("R8 take in control", src_take, 0);
            if (ann != 0) begin m_data = 1; m_rem = 8 * ann; end
        end else begin
            e = (m_sent < m_len) ? payload[m_sent] : 8'h00;
            chk("R8 data byte", tx_byte, e);
            chk("R8 take", src_take, (m_sent < m_len) ? 1 : 0);
            if (m_sent < m_len) m_sent++;
            m_rem--;
            if (m_rem == 0) begin m_data = 0; m_busy = 0; end
        end
        last_tx = tx_byte;
        got = (pr_rem > 0);
        if (got) pr_rem--;
        else begin m_pc = rb[2:0]; pr_rem = 8 * rb[5:3]; end
        @(posedge clk);
        @(negedge clk);
        slot = 1'b0;
        chk("R5 R12 sink valid", sink_valid, got);
        if (got) chk("R5 R12 sink data", sink_data, rb);
        chk("R9 busy", busy, m_busy);
    endtask

    task automatic do_req(input int len);
        bit was_busy;
        bit ok;
        was_busy = m_busy;
        ok = (len >= 1 && len <= 56);
        @(negedge clk);
        req = 1'b1;
        req_len = 6'(len);
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        if (was_busy) begin
            chk("R11 busy held", busy, 1);
            chk("R11 no err", err, 0);
        end else if (ok) begin
            m_busy = 1; m_words = (len + 7) / 8; m_len = len; m_sent = 0;
            chk("R7 accepted", busy, 1);
            chk("R7 no err", err, 0);
        end else begin
            chk("R10 err pulse", err, 1);
            chk("R10 not accepted", busy, 0);
            @(negedge clk);
            chk("R10 err one cycle", err, 0);
        end
    endtask

    function automatic logic [7:0] peer_byte();
        if (pr_rem > 0) return 8'($urandom);
        return {2'($urandom), (($urandom % 4) == 0) ? 3'($urandom) : 3'd0, 3'($urandom)};
    endfunction

    task automatic run_burst(input int len);
        int guard;
        fill(len);
        do_req(len);
        guard = 0;
        while ((m_busy || pr_rem > 0) && guard < 2000) begin
            sink_free = 8'($urandom);
            do_slot(peer_byte());
            guard++;
        end
        chk("R9 burst completed", busy, 0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20170506));
        fill(64);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_byte at reset", tx_byte, 8'h00);
        chk("R1 busy at reset", busy, 0);
        chk("R1 err at reset", err, 0);
        chk("R1 sink_valid at reset", sink_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero peer credit holds off a burst
        sink_free = 8'hFF;
        fill(8);
        do_req(8);
        do_slot(8'h00);
        chk("R1 no data without credit", last_tx[5:3], 0);
        // R4: top bits ignored, credit 7 loaded
        do_slot(8'hC7);
        chk("R1 still no data in loading slot", last_tx[5:3], 0);
        sink_free = 8'd23;
        do_slot(8'h00);
        chk("R4 burst announced after credit", last_tx, {2'b00, 3'd1, 3'd2});
        while (m_busy) do_slot(8'h00);

        // R10 rejected lengths
        do_req(0);
        do_req(57);
        do_req(63);

        // R6: data bytes that look like credit do not load it
        do_slot(8'h08);
        for (int i = 0; i < 8; i++) do_slot(8'h3F);
        fill(16);
        do_req(16);
        do_slot(8'h00);
        chk("R6 data bytes gave no credit", last_tx[5:3], 0);
        do_slot(8'h02);
        do_slot(8'h10);
        chk("R7 two words announced", last_tx[5:3], 2);
        // R11 request while busy
        do_req(5);
        // R12 receive burst while transmit is in data mode
        while (m_busy || pr_rem > 0) do_slot(pr_rem > 0 ? 8'($urandom) : 8'h00);

        // R8 padding corner lengths
        run_burst(1);
        run_burst(56);
        run_burst(9);

        for (int t = 0; t < 30; t++) run_burst(1 + int'($urandom % 56));

        summary();
        $finish;
    end
endmodule